// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading descriptors from a page table tree in memory. A walk starts from a context table pointer and a 16-bit context number. Each step issues one 32-bit word read on a valid/ready memory port and waits for the data. The two low bits of each descriptor give its entry type. A pointer descriptor names the next table. A leaf descriptor ends the walk. Invalid or reserved entries abort the walk with a fault.

A leaf can sit at the context level or at any of the three table levels. A shallow leaf maps a large page: 4 GB at the context level, 16 MB at level 1, 256 KB at level 2 and 4 KB at level 3. The physical address is built from the leaf's page number with the untranslated low virtual-address bits for that page size. The block does not check permissions or cache results. It only flags whether the referenced bit and the modified bit of the leaf would need to be set in memory.

Top module: `pgtbl_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and done is 0.
- R2: A request is taken only while req_ready is 1, which is only in the idle state. req_ready is 0 from the cycle after acceptance up to and including the done cycle, and is 1 again in the cycle after done.
- R3: The first read of a walk (level 0) goes to {P[31:4], 8'h00} + 4*ctx. P is ctx_tbl_ptr sampled at acceptance. Bits 3:0 of P are ignored.
- R4: A descriptor whose bits 1:0 equal 1 (table pointer), read at level n < 3, makes the next read go to level n+1. Its address is {D[31:4], 8'h00} + 4*index. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R5: A descriptor whose bits 1:0 equal 2 (leaf) ends the walk with walk_fault = 0. walk_level is the level it was read at, and walk_pte equals the descriptor. A walk ending at level L makes exactly L+1 reads.
- R6: After a leaf, walk_pa = {pte[31:8], 12'h000} with its low K bits replaced by VA[K-1:0]. K is 12 at level 3, 18 at level 2, 24 at level 1 and 32 at level 0.
- R7: Bits 1:0 equal to 0 give walk_fault = 1 (invalid). Bits 1:0 equal to 3 give walk_fault = 2 (reserved). A table pointer read at level 3 gives walk_fault = 3. In each case walk_level is the level of that descriptor and walk_pte equals it.
- R8: In the done cycle of a walk with no fault, need_ref = 1 exactly when pte bit 5 is 0. In the same case, need_mod = 1 exactly when req_write was 1 and pte bit 6 is 0. Both are 0 outside a faultless done cycle.
- R9: mem_req_valid is held with a stable address until mem_req_ready. At most one read is outstanding, so no new read is issued until its data returns.
- R10: done is high for exactly one cycle. walk_fault, walk_level, walk_pte and walk_pa hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 16 | Context number |
| req_write | input | 1 | Access is a store |
| ctx_tbl_ptr | input | 32 | Context table pointer; bits 31:4 are the base divided by 256 |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle walk completion pulse |
| walk_fault | output | 2 | 0 none, 1 invalid, 2 reserved, 3 pointer at last level |
| walk_level | output | 2 | Level of the last descriptor read |
| walk_pte | output | 32 | Last descriptor read |
| walk_pa | output | 36 | Translated physical address |
| need_ref | output | 1 | Referenced bit would need setting |
| need_mod | output | 1 | Modified bit would need setting |

## Verification
The completion pulse of one walk and the arrival of the next request can fall in the same cycle. A held request must not slip in while done is high. The bench provokes this by presenting a second request right after the first is accepted and holding req_valid through the first walk's done cycle. It judges the result by requiring req_ready to be low in the done cycle and high in the next one. It also requires the first result to match its own expected values, and the second walk's reads to start only after that, with its own expected result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } etype_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_INVALID  = 2'd1,
    FLT_RSVD     = 2'd2,
    FLT_DEEP_PTR = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } wstate_e;

  localparam logic [1:0] LAST_LVL = 2'd3;
endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 16,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [1:0]                lvl,
  input  logic [PA_W-1:0]           base,
  input  logic [L1_W+L2_W+L3_W-1:0] va_hi,
  input  logic [CTX_W-1:0]          ctx,
  output logic [PA_W-1:0]           addr
);
  localparam int L2_LO = L3_W;
  localparam int L1_LO = L3_W + L2_W;

  logic [PA_W-1:0] slot;

  always_comb begin
    unique case (lvl)
      2'd0:    slot = PA_W'(ctx);
      2'd1:    slot = PA_W'(va_hi[L1_LO +: L1_W]);
      2'd2:    slot = PA_W'(va_hi[L2_LO +: L2_W]);
      default: slot = PA_W'(va_hi[0 +: L3_W]);
    endcase
    addr = base + (slot << 2);
  end
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec import ptw_pkg::*; #(
  parameter int DW   = 32,
  parameter int PA_W = 36
) (
  input  logic [1:0]      etype,
  input  logic [DW-5:0]   ptr_field,
  input  logic [1:0]      lvl,
  output logic            descend,
  output fault_e          fault,
  output logic [PA_W-1:0] next_base
);
  localparam int PAD_W = PA_W - (DW - 4);

  assign next_base = {ptr_field, {PAD_W{1'b0}}};

  always_comb begin
    descend = 1'b0;
    fault   = FLT_NONE;
    unique case (etype_e'(etype))
      ET_INVALID: fault = FLT_INVALID;
      ET_RSVD:    fault = FLT_RSVD;
      ET_TABLE: begin
        if (lvl == LAST_LVL) fault = FLT_DEEP_PTR;
        else                 descend = 1'b1;
      end
      default: fault = FLT_NONE;
    endcase
  end
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  parameter int PPN_W = 24,
  parameter int PG_W  = 12,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       lvl,
  output logic [PA_W-1:0]  pa
);
  localparam int KEEP [0:3] = '{VA_W, VA_W - L1_W, PG_W + L3_W, PG_W};

  logic [PA_W-1:0] keep_mask [4];
  logic [PA_W-1:0] page_base;
  logic [PA_W-1:0] va_ext;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign keep_mask[g] = ~({PA_W{1'b1}} << KEEP[g]);
  end

  assign page_base = PA_W'({ppn, {PG_W{1'b0}}});
  assign va_ext    = PA_W'(va);
  assign pa        = (page_base & ~keep_mask[lvl]) | (va_ext & keep_mask[lvl]);
endmodule

// File: rtl/pgtbl_walker.sv
module pgtbl_walker import ptw_pkg::*; #(
  parameter int VA_W  = 32,
  parameter int DW    = 32,
  parameter int PA_W  = 36,
  parameter int CTX_W = 16,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int PG_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             req_write,
  input  logic [DW-1:0]    ctx_tbl_ptr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             done,
  output logic [1:0]       walk_fault,
  output logic [1:0]       walk_level,
  output logic [DW-1:0]    walk_pte,
  output logic [PA_W-1:0]  walk_pa,
  output logic             need_ref,
  output logic             need_mod
);
  localparam int PTR_LO = 4;
  localparam int PPN_LO = 8;
  localparam int PAD_W  = PA_W - (DW - PTR_LO);
  localparam int VHI_W  = L1_W + L2_W + L3_W;
  localparam int REF_B  = 5;
  localparam int MOD_B  = 6;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  wstate_e          state_q, state_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [PA_W-1:0]  base_q, base_d;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  logic             wr_q;
  logic [DW-1:0]    desc_q;
  fault_e           fault_q;

  logic             descend;
  fault_e           dec_fault;
  logic [PA_W-1:0]  next_base;
  logic [PA_W-1:0]  ctx_base;
  logic             ld_req, adv, fin, base_en;
  logic             unused_ptr_low;

  assign unused_ptr_low = ^ctx_tbl_ptr[PTR_LO-1:0];
  assign ctx_base       = {ctx_tbl_ptr[DW-1:PTR_LO], {PAD_W{1'b0}}};

  ptw_desc_dec #(.DW(DW), .PA_W(PA_W)) u_dec (
    .etype     (mem_rsp_data[1:0]),
    .ptr_field (mem_rsp_data[DW-1:PTR_LO]),
    .lvl       (lvl_q),
    .descend   (descend),
    .fault     (dec_fault),
    .next_base (next_base)
  );

  ptw_index_gen #(.PA_W(PA_W), .CTX_W(CTX_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_idx (
    .lvl   (lvl_q),
    .base  (base_q),
    .va_hi (va_q[VA_W-1 -: VHI_W]),
    .ctx   (ctx_q),
    .addr  (mem_req_addr)
  );

  ptw_pa_form #(.VA_W(VA_W), .PA_W(PA_W), .PPN_W(DW-PPN_LO), .PG_W(PG_W),
                .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_pa (
    .ppn (desc_q[DW-1:PPN_LO]),
    .va  (va_q),
    .lvl (lvl_q),
    .pa  (walk_pa)
  );

  assign ld_req  = (state_q == ST_IDLE) && req_valid;
  assign adv     = (state_q == ST_WAIT) && mem_rsp_valid && descend;
  assign fin     = (state_q == ST_WAIT) && mem_rsp_valid && !descend;
  assign base_en = ld_req || adv;
  assign base_d  = ld_req ? ctx_base : next_base;
  assign lvl_d   = ld_req ? 2'd0 : lvl_q + 2'd1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_FETCH;
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = descend ? ST_FETCH : ST_DONE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= 2'd0;
      base_q  <= '0;
      va_q    <= '0;
      ctx_q   <= '0;
      wr_q    <= 1'b0;
      desc_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (base_en) begin
        base_q <= base_d;
        lvl_q  <= lvl_d;
      end
      if (ld_req) begin
        va_q  <= req_vaddr;
        ctx_q <= req_ctx;
        wr_q  <= req_write;
      end
      if (fin) begin
        desc_q  <= mem_rsp_data;
        fault_q <= dec_fault;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign done          = (state_q == ST_DONE);
  assign walk_fault    = fault_q;
  assign walk_level    = lvl_q;
  assign walk_pte      = desc_q;
  assign need_ref      = done && (fault_q == FLT_NONE) && !desc_q[REF_B];
  assign need_mod      = done && (fault_q == FLT_NONE) && wr_q && !desc_q[MOD_B];
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [35:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic [1:0]  walk_fault,
  input logic [1:0]  walk_level,
  input logic [31:0] walk_pte,
  input logic        need_mod
);
  logic outst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid)                  outst_q <= 1'b0;
  end

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_valid);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_no_accept_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  a_r7_deep_ptr_level: assert property (@(posedge clk) disable iff (!rst_n)
    (done && walk_fault == 2'd3) |-> (walk_level == 2'd3 && walk_pte[1:0] == 2'b01));

  a_r5_leaf_type: assert property (@(posedge clk) disable iff (!rst_n)
    (done && walk_fault == 2'd0) |-> (walk_pte[1:0] == 2'b10));

  a_r8_mod_needs_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    need_mod |-> (done && walk_fault == 2'd0 && !walk_pte[6]));
endmodule

bind pgtbl_walker ptw_checker u_ptw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .walk_fault    (walk_fault),
  .walk_level    (walk_level),
  .walk_pte      (walk_pte),
  .need_mod      (need_mod)
);

// File: tb/test_pgtbl_walker.sv
`timescale 1ns/1ps
module test_pgtbl_walker;
  localparam logic [31:0] CTXP = 32'h0012_345F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr;
  logic [15:0] req_ctx;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_rsp_data;
  logic        done, need_ref, need_mod;
  logic [1:0]  walk_fault, walk_level;
  logic [31:0] walk_pte;
  logic [35:0] walk_pa;

  always #2 clk = ~clk;

  pgtbl_walker i_pgtbl_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctx(req_ctx), .req_write(req_write),
    .ctx_tbl_ptr(CTXP), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .walk_fault(walk_fault), .walk_level(walk_level), .walk_pte(walk_pte),
    .walk_pa(walk_pa), .need_ref(need_ref), .need_mod(need_mod)
  );

  // memory model
  logic [31:0] mem [logic [35:0]];
  logic [35:0] rd_log [0:255];
  logic [35:0] paddr_q;
  int  rd_cnt = 0;
  int  cyc = 0;
  int  lat = 0;
  int  gap = 1;
  int  lcnt = 0;
  int  ovl_err = 0;
  logic pend;

  function automatic logic [31:0] rdm(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  assign mem_req_ready = rst_n && !pend && !mem_rsp_valid && ((cyc % gap) == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pend          <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= 32'h0;
      lcnt          <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && pend) ovl_err <= ovl_err + 1;
      if (mem_req_valid && mem_req_ready) begin
        pend                <= 1'b1;
        paddr_q             <= mem_req_addr;
        lcnt                <= lat;
        rd_log[rd_cnt % 256] <= mem_req_addr;
        rd_cnt              <= rd_cnt + 1;
      end else if (pend) begin
        if (lcnt == 0) begin
          pend          <= 1'b0;
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rdm(paddr_q);
        end else lcnt <= lcnt - 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected values from the requirements
  logic [1:0]  e_lvl, e_flt;
  logic [31:0] e_pte;
  logic [35:0] e_pa;
  logic [35:0] e_addr [4];
  logic        e_ref, e_mod;
  int          e_n;

  function automatic logic [7:0] idx_of(input logic [31:0] va, input int k);
    case (k)
      1:       return va[31:24];
      2:       return {2'b00, va[23:18]};
      default: return {2'b00, va[17:12]};
    endcase
  endfunction

  task automatic model(input logic [31:0] va, input logic [15:0] ctx, input logic wr);
    logic [35:0] a, m;
    logic [31:0] d;
    int k, keep;
    bit fin;
    a = {CTXP[31:4], 8'h00} + {18'h0, ctx, 2'b00};
    k = 0; fin = 0; e_flt = 2'd0; d = 32'h0;
    while (!fin) begin
      e_addr[k] = a;
      d = rdm(a);
      case (d[1:0])
        2'd0: begin e_flt = 2'd1; fin = 1; end
        2'd3: begin e_flt = 2'd2; fin = 1; end
        2'd2: fin = 1;
        default: begin
          if (k == 3) begin e_flt = 2'd3; fin = 1; end
          else begin
            k++;
            a = {d[31:4], 8'h00} + {26'h0, idx_of(va, k), 2'b00};
          end
        end
      endcase
    end
    e_lvl = 2'(k); e_n = k + 1; e_pte = d;
    keep  = (k == 0) ? 32 : (k == 1) ? 24 : (k == 2) ? 18 : 12;
    m     = (36'h1 << keep) - 36'h1;
    e_pa  = ({d[31:8], 12'h000} & ~m) | ({4'h0, va} & m);
    e_ref = (e_flt == 2'd0) && !d[5];
    e_mod = (e_flt == 2'd0) && wr && !d[6];
  endtask

  logic [31:0] ptd [4];

  task automatic build(input int lv, input int t, input logic [31:0] va, input logic [15:0] ctx, input logic [5:0] flags);
    logic [35:0] a;
    mem.delete();
    for (int k = 0; k <= lv; k++) begin
      a = (k == 0) ? ({CTXP[31:4], 8'h00} + {18'h0, ctx, 2'b00})
                   : ({ptd[k-1][31:4], 8'h00} + {26'h0, idx_of(va, k), 2'b00});
      if (!mem.exists(a + 36'd4)) mem[a + 36'd4] = 32'hDEAD_BE02;
      if (k < lv) mem[a] = ptd[k];
      else case (t)
        0:       mem[a] = {va[31:8] ^ 24'h5A5A5A, 8'h54};
        1:       mem[a] = ptd[k];
        2:       mem[a] = {va[31:8] ^ 24'hC3C3C3, flags, 2'b10};
        default: mem[a] = {va[31:8] ^ 24'h0F0F0F, 8'h57};
      endcase
    end
  endtask

  task automatic wait_done(output bit ok);
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    ok = done;
    if (!ok) begin
      n_chk++; n_fail++;
      $display("FAIL R10 walk timeout: actual=no done expected=done");
    end
  endtask

  task automatic check_res(input int start, input logic [31:0] va, input logic [15:0] ctx, input logic wr);
    model(va, ctx, wr);
    chk("R7", walk_fault, e_flt, "fault code");
    chk("R5", walk_level, e_lvl, "level");
    chk("R5", walk_pte, e_pte, "descriptor");
    chk("R5", rd_cnt - start, e_n, "read count");
    for (int i = 0; i < e_n && i < 4; i++)
      chk(i == 0 ? "R3" : "R4", rd_log[(start + i) % 256], e_addr[i], "read address");
    if (e_flt == 2'd0) chk("R6", walk_pa, e_pa, "physical address");
    chk("R8", need_ref, e_ref, "need_ref");
    chk("R8", need_mod, e_mod, "need_mod");
    chk("R2", req_ready, 1'b0, "ready in done cycle");
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [15:0] ctx, input logic wr);
    int start; bit ok; logic [31:0] pte_seen;
    @(negedge clk);
    req_vaddr = va; req_ctx = ctx; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    start = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va; req_ctx = ~ctx;
    chk("R2", req_ready, 1'b0, "ready while walking");
    wait_done(ok);
    if (ok) begin
      check_res(start, va, ctx, wr);
      pte_seen = walk_pte;
      @(negedge clk);
      chk("R10", done, 1'b0, "done width");
      chk("R10", walk_pte, pte_seen, "result held");
      chk("R8", need_ref | need_mod, 1'b0, "need bits outside done");
      chk("R2", req_ready, 1'b1, "ready after done");
    end
  endtask

  initial begin
    int stA, stB; bit ok;
    logic [31:0] vas [3];
    logic [15:0] ctxs [3];
    logic [31:0] vaA, vaB;
    ptd[0] = 32'h3141_5921; ptd[1] = 32'hA5C3_7E0D;
    ptd[2] = 32'h0F00_1235; ptd[3] = 32'h7777_8889;
    vas[0] = 32'hFFFF_FFFF; vas[1] = 32'h0000_0000; vas[2] = 32'h9ABC_DEF1;
    ctxs[0] = 16'h0000; ctxs[1] = 16'hFFFF; ctxs[2] = 16'h1234;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_ctx = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", req_ready, 1'b1, "ready in reset");
    chk("R1", mem_req_valid, 1'b0, "mem valid in reset");
    chk("R1", done, 1'b0, "done in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", req_ready, 1'b1, "ready after reset");
    chk("R1", mem_req_valid, 1'b0, "mem valid after reset");
    chk("R1", done, 1'b0, "done after reset");

    // sweep: end level x entry type x address/context pattern
    for (int lv = 0; lv < 4; lv++)
      for (int t = 0; t < 4; t++)
        for (int v = 0; v < 3; v++) begin
          lat = (v + lv) % 3;
          gap = 1 + ((t + v) % 3);
          build(lv, t, vas[v], ctxs[v], {1'b1, lv[0], v[0] ^ lv[1], t[0], 2'b01});
          run_walk(vas[v], ctxs[v], (v == 1) || (v == 2 && lv[0]));
        end

    // second request held through the first walk's done cycle
    lat = 1; gap = 2;
    vaA = 32'h4E6D_5C3B; vaB = vaA ^ 32'h0100_0000;
    build(3, 2, vaA, 16'h0005, 6'b100001);
    @(negedge clk);
    req_vaddr = vaA; req_ctx = 16'h0005; req_write = 1'b1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    stA = rd_cnt;
    @(negedge clk);
    req_vaddr = vaB; req_write = 1'b0;
    chk("R2", req_ready, 1'b0, "second request held off");
    wait_done(ok);
    if (ok) begin
      check_res(stA, vaA, 16'h0005, 1'b1);
      @(negedge clk);
      chk("R2", req_ready, 1'b1, "held request taken after done");
      chk("R10", done, 1'b0, "done width back to back");
      stB = rd_cnt;
      chk("R9", stB - stA, 4, "no read of second walk before first result");
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(ok);
      if (ok) check_res(stB, vaB, 16'h0005, 1'b0);
    end
    repeat (3) @(negedge clk);
    chk("R9", ovl_err, 0, "reads issued while one outstanding");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule